// File: doc/BRIEF.md
# Serial Flash Clock and Chip-Select Sequencer

This block turns a fast reference clock into the serial clock and the active-low chip-select bus of a serial flash controller, and frames each transfer in time. A start pulse with a transfer length (counted in serial clock cycles) opens a frame. The block drives the chip-select pattern, waits a programmable lead time, and produces exactly twice the length in serial clock edges. It then holds for a programmable trail time, releases chip select, and enforces a programmable minimum deselect time before it reports idle again. When a frame addresses a different device from the one before it, a programmable switch-over gap is inserted ahead of the new chip-select assertion.

Two single-cycle strobes, launch and sample, tell the data lanes which serial clock edges move data and which capture it. Clock phase chooses whether the first edge after chip select is a sample edge or a launch edge. Clock polarity sets the idle level of the serial clock. The divider, polarity, phase, chip-select pattern and the delay word are copied into the block only while the enable bit is low and no frame is running. Changing them at any other time has no effect on the frame in progress or on later frames.

Top module: `sclk_cs_sequencer`

## Requirements
- R1: After reset, csN is 4'hF, sclk is 0 and idle is 1. Whenever idle is 1, csN is 4'hF and sclk rests at the captured polarity level.
- R2: The serial clock half period is div+1 reference clocks. div is the 4-bit field at cfgWord[22:19], so the full period is 2*(div+1). Each frame produces exactly 2*xferLen sclk edges, evenly spaced.
- R3: cfgWord[0] is enable, cfgWord[1] is polarity and cfgWord[2] is phase. A start pulse opens a frame only when enable is 1, idle is 1 and xferLen is non-zero. Any other start pulse is ignored, and the outputs stay at their idle values.
- R4: Divider, polarity, phase, chip-select field, decode bit and the delay word are captured only in cycles where enable is 0 and idle is 1. A change made while enable is 1 alters neither the running frame nor later frames.
- R5: During a frame, csN carries the 4-bit field cfgWord[13:10] exactly as written, for example one-hot-low 4'hB for device 2 or any code for an external decoder. Setting the decode bit cfgWord[9] does not change the driven value.
- R6: The first sclk edge comes lead+div+1 reference clocks after csN falls, where lead = dlyWord[7:0].
- R7: csN returns to 4'hF trail+2*(div+1)+3 reference clocks after the last sclk edge, where trail = dlyWord[15:8].
- R8: idle rises hold+2*(div+1)+1 reference clocks after csN returns to 4'hF, where hold = dlyWord[31:24].
- R9: If an earlier frame exists and the chip-select field differs from that frame's, csN falls gap reference clocks after the accepting edge, where gap = dlyWord[23:16]. Otherwise csN falls on the accepting edge itself.
- R10: Each frame gives xferLen launch and xferLen sample pulses, each one cycle wide and never both in the same cycle. With phase 0, the first launch coincides with the csN fall and sample pulses coincide with odd-numbered edges. With phase 1, launches coincide with odd-numbered edges and samples with even-numbered edges.
- R11: idle goes to 0 on the accepting edge and stays 0 until the deselect time of R8 expires. A start pulse that arrives during a frame is ignored and opens no second frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWord | input | 32 | Configuration word: enable, polarity, phase, decode, chip-select field, divider |
| dlyWord | input | 32 | Four 8-bit timing counts: lead, trail, gap, hold |
| start | input | 1 | One-cycle request to open a frame |
| xferLen | input | 8 | Frame length in serial clock cycles |
| sclk | output | 1 | Serial clock |
| csN | output | 4 | Active-low chip-select bus |
| launchPulse | output | 1 | Strobe on cycles where outgoing data should change |
| samplePulse | output | 1 | Strobe on cycles where incoming data should be captured |
| idle | output | 1 | High when no frame is pending and all post-frame delays have expired |

## Verification
The bench targets zero lead, gap and hold counts, which must skip their phases rather than wrap to 255. It also drives the widest divider, where a wrong half period would stretch or shrink every edge spacing. It alternates between equal and different chip-select values so that a missing or unconditional switch-over gap shows up as a wrong fall time. It rewrites the divider mid-frame with enable still high, and it pulses start during a frame. A design that ignores the capture rule would change edge spacing, and a design that accepts the stray start would produce extra edges or a second frame. Both phase settings are run, because swapped launch and sample strobes would move the first sample by one half period.

// File: rtl/sclk_cs_seq_pkg.sv
package sclk_cs_seq_pkg;

  // configuration word field positions
  localparam int CFG_EN      = 0;
  localparam int CFG_CPOL    = 1;
  localparam int CFG_CPHA    = 2;
  localparam int CFG_CS_LSB  = 10;
  localparam int CFG_DIV_LSB = 19;

  // delay word field positions
  localparam int DLY_LEAD_LSB  = 0;
  localparam int DLY_TRAIL_LSB = 8;
  localparam int DLY_GAP_LSB   = 16;
  localparam int DLY_HOLD_LSB  = 24;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP,
    ST_LEAD,
    ST_CLK,
    ST_TRAIL,
    ST_HOLD
  } seqState_t;

  typedef struct packed {
    logic csAssert;
    logic csRelease;
    logic sclkToggle;
    logic sclkPark;
    logic launch;
    logic sample;
  } seqStrobe_t;

endpackage

// File: rtl/sclk_cs_seq_ctrl.sv
module sclk_cs_seq_ctrl
  import sclk_cs_seq_pkg::*;
#(
  parameter int DIV_W = 4,
  parameter int CS_W  = 4,
  parameter int DLY_W = 8,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [31:0]      cfgWord,
  input  logic [31:0]      dlyWord,
  input  logic             start,
  input  logic [LEN_W-1:0] xferLen,
  output seqStrobe_t       stb,
  output logic [CS_W-1:0]  csSel,
  output logic             cpolSel,
  output logic             idle
);

  localparam int WIDE_W = (DLY_W > DIV_W + 1) ? DLY_W : DIV_W + 1;
  localparam int CNT_W  = WIDE_W + 2;
  localparam int EDGE_W = LEN_W + 1;

  seqState_t state, stateNxt;
  logic [CNT_W-1:0]  cnt, cntNxt;
  logic [EDGE_W-1:0] edgeCnt, edgeNxt, edgeNum;
  logic [DIV_W-1:0]  divS;
  logic              cpolS, cphaS;
  logic [CS_W-1:0]   csS, lastCs;
  logic              lastValid;
  logic [DLY_W-1:0]  leadS, trailS, gapS, holdS;
  logic [LEN_W-1:0]  lenS;
  logic              cfgEn, accept, gapNeed, selectNow, lastEdgeHit, captureNow;
  logic [CNT_W-1:0]  divWide, trailLoad, holdLoad;
  logic              unusedCfg;

  assign cfgEn      = cfgWord[CFG_EN];
  assign unusedCfg  = ^cfgWord;
  assign accept     = start && cfgEn && (state == ST_IDLE) && (xferLen != '0);
  assign gapNeed    = lastValid && (csS != lastCs) && (gapS != '0);
  assign captureNow = !cfgEn && (state == ST_IDLE);
  assign divWide    = CNT_W'(divS);
  assign trailLoad  = CNT_W'(trailS) + (divWide << 1) + CNT_W'(4);
  assign holdLoad   = CNT_W'(holdS) + (divWide << 1) + CNT_W'(2);
  assign edgeNum    = edgeCnt + EDGE_W'(1);
  assign lastEdgeHit = (edgeNum == {lenS, 1'b0});

  always_comb begin
    stateNxt  = state;
    cntNxt    = cnt;
    edgeNxt   = edgeCnt;
    stb       = '0;
    selectNow = 1'b0;
    case (state)
      ST_IDLE: begin
        stb.sclkPark = 1'b1;
        if (accept) begin
          if (gapNeed) begin
            stateNxt = ST_GAP;
            cntNxt   = CNT_W'(gapS) - CNT_W'(1);
          end else begin
            selectNow = 1'b1;
          end
        end
      end
      ST_GAP: begin
        if (cnt == '0) selectNow = 1'b1;
        else cntNxt = cnt - CNT_W'(1);
      end
      ST_LEAD: begin
        if (cnt == '0) begin
          stateNxt = ST_CLK;
          cntNxt   = divWide;
        end else begin
          cntNxt = cnt - CNT_W'(1);
        end
      end
      ST_CLK: begin
        if (cnt == '0) begin
          stb.sclkToggle = 1'b1;
          edgeNxt        = edgeNum;
          if (edgeNum[0]) begin
            stb.sample = !cphaS;
            stb.launch = cphaS;
          end else begin
            stb.sample = cphaS;
            stb.launch = !cphaS && !lastEdgeHit;
          end
          if (lastEdgeHit) begin
            stateNxt = ST_TRAIL;
            cntNxt   = trailLoad;
          end else begin
            cntNxt = divWide;
          end
        end else begin
          cntNxt = cnt - CNT_W'(1);
        end
      end
      ST_TRAIL: begin
        if (cnt == '0) begin
          stb.csRelease = 1'b1;
          stateNxt      = ST_HOLD;
          cntNxt        = holdLoad;
        end else begin
          cntNxt = cnt - CNT_W'(1);
        end
      end
      ST_HOLD: begin
        if (cnt == '0) stateNxt = ST_IDLE;
        else cntNxt = cnt - CNT_W'(1);
      end
      default: stateNxt = ST_IDLE;
    endcase

    if (selectNow) begin
      stb.csAssert = 1'b1;
      stb.launch   = !cphaS;
      edgeNxt      = '0;
      if (leadS != '0) begin
        stateNxt = ST_LEAD;
        cntNxt   = CNT_W'(leadS) - CNT_W'(1);
      end else begin
        stateNxt = ST_CLK;
        cntNxt   = divWide;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      edgeCnt   <= '0;
      divS      <= '0;
      cpolS     <= 1'b0;
      cphaS     <= 1'b0;
      csS       <= '1;
      leadS     <= '0;
      trailS    <= '0;
      gapS      <= '0;
      holdS     <= '0;
      lenS      <= '0;
      lastCs    <= '1;
      lastValid <= 1'b0;
    end else begin
      state   <= stateNxt;
      cnt     <= cntNxt;
      edgeCnt <= edgeNxt;
      if (captureNow) begin
        divS   <= cfgWord[CFG_DIV_LSB +: DIV_W];
        cpolS  <= cfgWord[CFG_CPOL];
        cphaS  <= cfgWord[CFG_CPHA];
        csS    <= cfgWord[CFG_CS_LSB +: CS_W];
        leadS  <= dlyWord[DLY_LEAD_LSB +: DLY_W];
        trailS <= dlyWord[DLY_TRAIL_LSB +: DLY_W];
        gapS   <= dlyWord[DLY_GAP_LSB +: DLY_W];
        holdS  <= dlyWord[DLY_HOLD_LSB +: DLY_W];
      end
      if (accept) lenS <= xferLen;
      if (selectNow) begin
        lastCs    <= csS;
        lastValid <= 1'b1;
      end
    end
  end

  assign csSel   = csS;
  assign cpolSel = cpolS;
  assign idle    = (state == ST_IDLE);

  // settings held for the whole frame
  assert_settings_frozen_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |=> ($stable(divS) && $stable(cpolS) && $stable(cphaS) &&
                            $stable(csS) && $stable(leadS) && $stable(trailS) && $stable(holdS)));

  // edge counter never runs past the frame length
  assert_edge_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CLK) |-> (edgeCnt < {lenS, 1'b0}));

  // a start while busy keeps the length of the running frame
  assert_busy_start_ignored_R11: assert property (@(posedge clk) disable iff (!rstN)
    (start && state != ST_IDLE) |=> $stable(lenS));

endmodule

// File: rtl/sclk_cs_seq_datapath.sv
module sclk_cs_seq_datapath
  import sclk_cs_seq_pkg::*;
#(
  parameter int CS_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  seqStrobe_t      stb,
  input  logic [CS_W-1:0] csSel,
  input  logic            cpolSel,
  output logic            sclk,
  output logic [CS_W-1:0] csN,
  output logic            launchPulse,
  output logic            samplePulse
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclk        <= 1'b0;
      csN         <= '1;
      launchPulse <= 1'b0;
      samplePulse <= 1'b0;
    end else begin
      launchPulse <= stb.launch;
      samplePulse <= stb.sample;
      if (stb.csAssert) csN <= csSel;
      else if (stb.csRelease) csN <= '1;
      if (stb.sclkToggle) sclk <= ~sclk;
      else if (stb.sclkPark) sclk <= cpolSel;
    end
  end

  // the selected pattern does not move within a frame
  assert_cs_steady_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(csN) != '1 && csN != '1) |-> (csN == $past(csN)));

  assert_pulse_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(launchPulse && samplePulse));

  assert_sample_on_edge_R10: assert property (@(posedge clk) disable iff (!rstN)
    samplePulse |-> (sclk != $past(sclk)));

endmodule

// File: rtl/sclk_cs_sequencer.sv
module sclk_cs_sequencer
  import sclk_cs_seq_pkg::*;
#(
  parameter int DIV_W = 4,
  parameter int CS_W  = 4,
  parameter int DLY_W = 8,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [31:0]      cfgWord,
  input  logic [31:0]      dlyWord,
  input  logic             start,
  input  logic [LEN_W-1:0] xferLen,
  output logic             sclk,
  output logic [CS_W-1:0]  csN,
  output logic             launchPulse,
  output logic             samplePulse,
  output logic             idle
);

  seqStrobe_t      stb;
  logic [CS_W-1:0] csSel;
  logic            cpolSel;

  sclk_cs_seq_ctrl #(
    .DIV_W(DIV_W), .CS_W(CS_W), .DLY_W(DLY_W), .LEN_W(LEN_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWord(cfgWord), .dlyWord(dlyWord),
    .start(start), .xferLen(xferLen), .stb(stb), .csSel(csSel),
    .cpolSel(cpolSel), .idle(idle)
  );

  sclk_cs_seq_datapath #(.CS_W(CS_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .csSel(csSel), .cpolSel(cpolSel),
    .sclk(sclk), .csN(csN), .launchPulse(launchPulse), .samplePulse(samplePulse)
  );

  // idle means no device is selected
  assert_idle_deselected_R1: assert property (@(posedge clk) disable iff (!rstN)
    idle |-> (csN == '1));

  // no strobes leave the block while it reports idle
  assert_idle_no_strobes_R11: assert property (@(posedge clk) disable iff (!rstN)
    (idle && $past(idle)) |-> !(launchPulse || samplePulse));

endmodule

// File: tb/sclk_cs_sequencer_test.sv
`timescale 1ns/1ps
module sclk_cs_sequencer_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] cfgWord = '0;
  logic [31:0] dlyWord = '0;
  logic        start = 1'b0;
  logic [7:0]  xferLen = '0;
  logic        sclk, launchPulse, samplePulse, idle;
  logic [3:0]  csN;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  int curDiv, curLead, curTrail, curGap, curHold;
  bit curCpol, curCpha, curDec;
  logic [3:0] curCs;
  logic [3:0] tbLastCs = 4'hF;
  bit tbLastValid = 0;

  sclk_cs_sequencer uut (
    .clk(clk), .rstN(rstN), .cfgWord(cfgWord), .dlyWord(dlyWord),
    .start(start), .xferLen(xferLen), .sclk(sclk), .csN(csN),
    .launchPulse(launchPulse), .samplePulse(samplePulse), .idle(idle)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] mkCfg(bit en, bit cpol, bit cpha, bit dec,
                                        logic [3:0] cs, int div);
    logic [31:0] w = '0;
    w[0] = en; w[1] = cpol; w[2] = cpha; w[9] = dec;
    w[13:10] = cs;
    w[22:19] = div[3:0];
    return w;
  endfunction

  function automatic logic [31:0] mkDly(int lead, int trail, int gap, int hold);
    return {hold[7:0], gap[7:0], trail[7:0], lead[7:0]};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply(int div, bit cpol, bit cpha, bit dec, logic [3:0] cs,
                       int lead, int trail, int gap, int hold);
    curDiv = div; curCpol = cpol; curCpha = cpha; curDec = dec; curCs = cs;
    curLead = lead; curTrail = trail; curGap = gap; curHold = hold;
    @(negedge clk);
    cfgWord = mkCfg(0, cpol, cpha, dec, cs, div);
    dlyWord = mkDly(lead, trail, gap, hold);
    repeat (3) @(negedge clk);
    cfgWord = mkCfg(1, cpol, cpha, dec, cs, div);
    @(negedge clk);
  endtask

  task automatic runXfer(int n, bit midStart, bit midCfg);
    int startCyc, csFall, firstEdge, lastEdge, edges, csRise, idleCyc;
    int launches, samples, firstL, firstS, expG, h;
    bit prevS, spacingOk, csOk;
    logic [3:0] seen;
    h = curDiv + 1;
    expG = (tbLastValid && curCs != tbLastCs && curGap != 0) ? curGap : 0;
    csFall = -1; firstEdge = -1; lastEdge = -1; csRise = -1; idleCyc = -1;
    edges = 0; launches = 0; samples = 0; firstL = -1; firstS = -1;
    spacingOk = 1; csOk = 1; seen = 4'hF;
    @(negedge clk);
    prevS = sclk; xferLen = n[7:0]; start = 1'b1; startCyc = cyc + 1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 6000; i++) begin
      if (i > 0) @(negedge clk);
      if (midStart) start = (cyc == startCyc + 2);
      if (midCfg && cyc == startCyc + 2)
        cfgWord = mkCfg(1, curCpol, curCpha, curDec, curCs, curDiv ^ 5);
      if (csFall < 0 && csN != 4'hF) begin csFall = cyc; seen = csN; end
      else if (csFall >= 0 && csRise < 0 && csN == 4'hF) csRise = cyc;
      else if (csFall >= 0 && csRise < 0 && csN != seen) csOk = 0;
      if (sclk != prevS) begin
        edges++;
        if (firstEdge < 0) firstEdge = cyc;
        else if (cyc - lastEdge != h) spacingOk = 0;
        lastEdge = cyc;
      end
      prevS = sclk;
      if (launchPulse) begin launches++; if (firstL < 0) firstL = cyc; end
      if (samplePulse) begin samples++; if (firstS < 0) firstS = cyc; end
      if (idle) begin idleCyc = cyc; break; end
    end
    start = 1'b0;
    chk(csFall - startCyc == expG, "R9 cs fall offset", csFall - startCyc, expG);
    chk(seen == curCs && csOk, "R5 cs value", int'(seen), int'(curCs));
    chk(firstEdge - csFall == curLead + h, "R6 lead", firstEdge - csFall, curLead + h);
    chk(edges == 2 * n && spacingOk, "R2 edges/spacing", edges, 2 * n);
    chk(csRise - lastEdge == curTrail + 2 * h + 3, "R7 trail", csRise - lastEdge,
        curTrail + 2 * h + 3);
    chk(idleCyc - csRise == curHold + 2 * h + 1, "R8 hold", idleCyc - csRise,
        curHold + 2 * h + 1);
    chk(launches == n && samples == n, "R10 pulse counts", launches * 100 + samples,
        n * 100 + n);
    chk(firstS == csFall + curLead + (curCpha ? 2 : 1) * h, "R10 first sample",
        firstS - csFall, curLead + (curCpha ? 2 : 1) * h);
    chk(firstL == (curCpha ? firstEdge : csFall), "R10 first launch", firstL,
        curCpha ? firstEdge : csFall);
    chk(sclk == curCpol, "R1 idle level", int'(sclk), int'(curCpol));
    tbLastCs = curCs; tbLastValid = 1;
    if (midStart) begin
      repeat (4) @(negedge clk);
      chk(idle && csN == 4'hF, "R11 busy start ignored", int'(csN), 15);
    end
  endtask

  task automatic ignoredStart(int n, string req);
    @(negedge clk);
    xferLen = n[7:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (6) begin
      @(negedge clk);
      if (!idle || csN != 4'hF || sclk != curCpol || launchPulse) begin
        chk(0, req, int'(csN), 15);
        return;
      end
    end
    chk(1, req, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int seedVal;
    seedVal = $urandom(32'h1bad5eed);
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(csN == 4'hF && sclk == 1'b0 && idle == 1'b1 && !launchPulse && !samplePulse,
        "R1 reset", int'({idle, sclk, csN}), 'h2F);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1/R12 idle level follows polarity
    apply(0, 1, 0, 0, 4'hE, 0, 0, 0, 0);
    chk(sclk == 1'b1, "R1 idle high with polarity", int'(sclk), 1);

    // R3: disabled start and zero length are ignored
    cfgWord = mkCfg(0, curCpol, curCpha, curDec, curCs, curDiv);
    ignoredStart(3, "R3 start while disabled");
    cfgWord = mkCfg(1, curCpol, curCpha, curDec, curCs, curDiv);
    ignoredStart(0, "R3 zero length");

    // minimal frame: all counts zero
    runXfer(1, 0, 0);
    apply(0, 0, 1, 0, 4'hE, 0, 0, 0, 0);
    runXfer(3, 0, 0);

    // R9: different device inserts the gap, same device does not
    apply(1, 0, 0, 0, 4'hD, 2, 1, 5, 3);
    runXfer(2, 0, 0);
    runXfer(2, 0, 0);

    // R5: decode mode drives an arbitrary code unchanged
    apply(2, 1, 1, 1, 4'h5, 1, 0, 3, 0);
    runXfer(2, 0, 0);

    // R2: widest divider
    apply(15, 0, 0, 0, 4'h7, 4, 2, 0, 1);
    runXfer(2, 0, 0);

    // R4: divider rewritten while enabled has no effect, now or later
    apply(1, 0, 1, 0, 4'hB, 3, 2, 1, 2);
    runXfer(4, 0, 1);
    runXfer(2, 0, 0);

    // R11: start pulse during a frame
    apply(2, 1, 0, 0, 4'hB, 1, 1, 1, 1);
    runXfer(3, 1, 0);

    // constrained random frames
    for (int k = 0; k < 24; k++) begin
      logic [3:0] cs;
      cs = 4'($urandom_range(0, 14));
      apply($urandom_range(0, 3), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 1)), cs, $urandom_range(0, 6), $urandom_range(0, 6),
            $urandom_range(0, 6), $urandom_range(0, 6));
      runXfer($urandom_range(1, 6), 0, 0);
    end

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule